// File: doc/BRIEF.md
# Load/Store Lane Formatter with Persistent Size Mode

This block sits between a 32-bit core and its operand memory. On loads it takes the word that memory returns and turns it into the value written to a register. A full-word access passes the word through unchanged. A sub-word access picks the addressed byte or halfword out of the little-endian word, then either zero-fills or sign-extends it to the full width.

The opcode carries only one bit that separates full-word from not-word accesses. The width and signedness of a not-word access come from a small size-mode register that software writes and that keeps its value between accesses. That register also holds a mode bit that is passed on to the ALU, which selects 16-bit instead of 32-bit overflow detection.

On stores the block copies the source data across every lane and produces byte enables from the low address bits and the access size. Accesses at an address that does not suit their size are flagged, and no register write or byte-enable is produced for them. All outputs are combinational from the inputs and the size-mode register.

Top module: `ldst_lane_fmt`

## Requirements
- R1: After reset the size-mode register is 3'b000: unsigned byte for not-word accesses, and `ovf16_mode` low.
- R2: `sz_wdata` is captured into the size-mode register at a clock edge where `sz_we` is high, and takes effect from the next cycle. With `sz_we` low the register keeps its value.
- R3: With `acc_word` high, `ld_data` equals `mem_rdata` unchanged.
- R4: A not-word access with size-mode bit0 = 0 (byte) and bit1 = 0 (unsigned) returns byte lane `addr_lo`, where lane k is bits 8k+7..8k, zero-filled in bits 31..8.
- R5: With size-mode bit1 = 1 (signed), a not-word byte or halfword result is sign-extended from its top bit.
- R6: A not-word access with size-mode bit0 = 1 (halfword) returns bits 15..0 (`addr_lo` = 0) or bits 31..16 (`addr_lo` = 2) of `mem_rdata`, zero-filled in bits 31..16 when bit1 = 0.
- R7: `misalign` is high when a load or store is requested as a word with `addr_lo` not 0, or as a halfword with `addr_lo` odd. Byte accesses never raise it, and neither do idle cycles.
- R8: `rf_we` is high exactly when `ld_req` is high and the access is not misaligned.
- R9: `mem_be` is zero unless `st_req` is high and the access is aligned. Then it is 4'b1111 for a word, 4'b0011 shifted left by `addr_lo` for a halfword, and 4'b0001 shifted left by `addr_lo` for a byte.
- R10: `mem_wdata` is `st_wdata` for a word store, its bits 15..0 repeated twice for a halfword, and its bits 7..0 repeated four times for a byte.
- R11: `ovf16_mode` always shows size-mode bit2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sz_we | input | 1 | Write strobe for the size-mode register |
| sz_wdata | input | 3 | New size mode: bit0 halfword, bit1 signed, bit2 16-bit overflow |
| ld_req | input | 1 | Load request this cycle |
| st_req | input | 1 | Store request this cycle |
| acc_word | input | 1 | Opcode width bit: 1 full word, 0 not-word |
| addr_lo | input | 2 | Low address bits of the access |
| mem_rdata | input | 32 | Word returned by operand memory |
| st_wdata | input | 32 | Store source register value |
| ld_data | output | 32 | Formatted register write value |
| rf_we | output | 1 | Register write permitted |
| misalign | output | 1 | Access address unsuitable for its size |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_be | output | 4 | Store byte enables, bit k for lane k |
| ovf16_mode | output | 1 | 16-bit overflow detection select for the ALU |

## Verification
The assertions take for granted that a load and a store are never requested in the same cycle. They also assume that the size-mode strobe is held low while reset is asserted, so the register's first value after reset is its reset value. The stimulus picks exactly one of idle, load or store in each cycle, and drives `sz_we` low throughout reset. Random addresses, data and occasional size-mode writes then cover every size, sign and lane combination, aligned and misaligned.

// File: rtl/ldst_lane_fmt.sv
module ldst_lane_fmt #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sz_we,
  input  logic [2:0]    sz_wdata,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          acc_word,
  input  logic [AW-1:0] addr_lo,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] st_wdata,
  output logic [DW-1:0] ld_data,
  output logic          rf_we,
  output logic          misalign,
  output logic [DW-1:0] mem_wdata,
  output logic [NB-1:0] mem_be,
  output logic          ovf16_mode
);

  logic [2:0]    size_q;
  logic [DW-1:0] lane;
  logic [NB-1:0] be_raw;
  logic          bad_align;
  logic          sz_half, sz_sgn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     size_q <= 3'b000;
    else if (sz_we) size_q <= sz_wdata;

  assign sz_half    = size_q[0];
  assign sz_sgn     = size_q[1];
  assign ovf16_mode = size_q[2];

  assign lane = mem_rdata >> {addr_lo, 3'b000};

  always_comb begin
    if (acc_word)     bad_align = |addr_lo;
    else if (sz_half) bad_align = addr_lo[0];
    else              bad_align = 1'b0;
  end

  assign misalign = (ld_req | st_req) & bad_align;
  assign rf_we    = ld_req & ~bad_align;

  always_comb begin
    if (acc_word)     ld_data = mem_rdata;
    else if (sz_half) ld_data = {{(DW-16){sz_sgn & lane[15]}}, lane[15:0]};
    else              ld_data = {{(DW-8){sz_sgn & lane[7]}}, lane[7:0]};
  end

  always_comb begin
    if (acc_word)     be_raw = '1;
    else if (sz_half) be_raw = NB'(3) << addr_lo;
    else              be_raw = NB'(1) << addr_lo;
  end

  assign mem_be = (st_req & ~bad_align) ? be_raw : '0;

  always_comb begin
    if (acc_word)     mem_wdata = st_wdata;
    else if (sz_half) mem_wdata = {(NB/2){st_wdata[15:0]}};
    else              mem_wdata = {NB{st_wdata[7:0]}};
  end

endmodule

// File: rtl/ldst_lane_fmt_chk.sv
module ldst_lane_fmt_chk #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sz_we,
  input logic          ld_req,
  input logic          st_req,
  input logic          acc_word,
  input logic [AW-1:0] addr_lo,
  input logic [DW-1:0] ld_data,
  input logic          rf_we,
  input logic          misalign,
  input logic [NB-1:0] mem_be,
  input logic [2:0]    size_q
);

  // R8
  rf_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (ld_req && !misalign));

  // R7
  word_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_req || st_req) && acc_word && addr_lo != '0) |-> (misalign && !rf_we && mem_be == '0));

  // R9
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |-> (mem_be == '0));

  // R9
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !misalign) |-> ($countones(mem_be) == (acc_word ? NB : (size_q[0] ? 2 : 1))));

  // R4
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !acc_word && size_q[1:0] == 2'b00) |-> (ld_data[DW-1:8] == '0));

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !acc_word && size_q[1:0] == 2'b10) |-> (ld_data[DW-1:8] == {(DW-8){ld_data[7]}}));

  // R2
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sz_we |=> $stable(size_q));

endmodule

bind ldst_lane_fmt ldst_lane_fmt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sz_we(sz_we), .ld_req(ld_req), .st_req(st_req),
  .acc_word(acc_word), .addr_lo(addr_lo), .ld_data(ld_data), .rf_we(rf_we),
  .misalign(misalign), .mem_be(mem_be), .size_q(size_q)
);

// File: tb/ldst_lane_fmt_bench.sv
module ldst_lane_fmt_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n, sz_we, ld_req, st_req, acc_word;
  logic [2:0]  sz_wdata;
  logic [1:0]  addr_lo;
  logic [31:0] mem_rdata, st_wdata, ld_data, mem_wdata;
  logic        rf_we, misalign, ovf16_mode;
  logic [3:0]  mem_be;

  ldst_lane_fmt u_ldst_lane_fmt (
    .clk(clk), .rst_n(rst_n), .sz_we(sz_we), .sz_wdata(sz_wdata),
    .ld_req(ld_req), .st_req(st_req), .acc_word(acc_word), .addr_lo(addr_lo),
    .mem_rdata(mem_rdata), .st_wdata(st_wdata), .ld_data(ld_data), .rf_we(rf_we),
    .misalign(misalign), .mem_wdata(mem_wdata), .mem_be(mem_be), .ovf16_mode(ovf16_mode)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] msz = 3'b000;
  logic       pend_we = 1'b0;
  logic [2:0] pend_sz = 3'b000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_ld(bit w, logic [1:0] a, logic [31:0] d, logic [2:0] s);
    logic [31:0] sh;
    sh = d >> {a, 3'b000};
    if (w) return d;
    if (s[0]) return s[1] ? {{16{sh[15]}}, sh[15:0]} : {16'h0, sh[15:0]};
    return s[1] ? {{24{sh[7]}}, sh[7:0]} : {24'h0, sh[7:0]};
  endfunction

  function automatic bit e_bad(bit w, logic [1:0] a, logic [2:0] s);
    if (w) return a != 2'd0;
    if (s[0]) return a[0];
    return 1'b0;
  endfunction

  function automatic logic [3:0] e_be(bit w, logic [1:0] a, logic [2:0] s);
    if (w) return 4'hF;
    if (s[0]) return 4'b0011 << a;
    return 4'b0001 << a;
  endfunction

  function automatic logic [31:0] e_wd(bit w, logic [31:0] d, logic [2:0] s);
    if (w) return d;
    if (s[0]) return {2{d[15:0]}};
    return {4{d[7:0]}};
  endfunction

  task automatic step(bit ld, bit st, bit w, logic [1:0] a, logic [31:0] rd,
                      logic [31:0] wd, bit we, logic [2:0] wsz);
    bit b;
    string lt;
    @(posedge clk);
    if (pend_we) msz = pend_sz;
    #1;
    ld_req = ld; st_req = st; acc_word = w; addr_lo = a;
    mem_rdata = rd; st_wdata = wd; sz_we = we; sz_wdata = wsz;
    #(CLK_P/2 - 1);
    b  = e_bad(w, a, msz);
    lt = w ? "R3" : (msz[0] ? "R6" : (msz[1] ? "R5" : "R4"));
    chk(lt, ld_data, e_ld(w, a, rd, msz));
    chk("R7", {31'b0, misalign}, {31'b0, (ld | st) & b});
    chk("R8", {31'b0, rf_we}, {31'b0, ld & ~b});
    chk("R9", {28'b0, mem_be}, (st && !b) ? {28'b0, e_be(w, a, msz)} : 32'h0);
    chk("R10", mem_wdata, e_wd(w, wd, msz));
    chk("R11", {31'b0, ovf16_mode}, {31'b0, msz[2]});
    pend_we = we; pend_sz = wsz;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; sz_we = 1'b0; sz_wdata = 3'b111; ld_req = 1'b0; st_req = 1'b0;
    acc_word = 1'b0; addr_lo = 2'd0; mem_rdata = '0; st_wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    chk("R1", {31'b0, ovf16_mode}, 32'h0);
    rst_n = 1'b1;

    step(1, 0, 0, 2'd0, 32'hFFFF_FF80, 0, 0, 3'b000);
    chk("R1", ld_data, 32'h0000_0080);

    step(0, 0, 0, 2'd0, 0, 0, 1, 3'b110);
    step(1, 0, 0, 2'd3, 32'h8011_2233, 0, 0, 3'b001);
    chk("R2", {31'b0, ovf16_mode}, 32'h1);
    chk("R5", ld_data, 32'hFFFF_FF80);
    step(0, 0, 0, 2'd0, 0, 0, 0, 3'b001);
    chk("R2", {31'b0, ovf16_mode}, 32'h1);

    step(0, 0, 0, 2'd0, 0, 0, 1, 3'b011);
    step(1, 0, 0, 2'd2, 32'h9ABC_1234, 0, 0, 3'b000);
    chk("R6", ld_data, 32'hFFFF_9ABC);
    step(1, 0, 0, 2'd1, 32'h9ABC_1234, 0, 0, 3'b000);
    chk("R7", {31'b0, misalign}, 32'h1);
    step(0, 1, 0, 2'd3, 0, 32'h0000_BEEF, 0, 3'b000);
    chk("R9", {28'b0, mem_be}, 32'h0);
    step(0, 1, 0, 2'd2, 0, 32'h1234_BEEF, 0, 3'b000);
    chk("R9", {28'b0, mem_be}, 32'hC);
    chk("R10", mem_wdata, 32'hBEEF_BEEF);

    step(0, 0, 0, 2'd0, 0, 0, 1, 3'b000);
    step(0, 1, 0, 2'd1, 0, 32'h0000_00A5, 0, 3'b000);
    chk("R9", {28'b0, mem_be}, 32'h2);
    chk("R10", mem_wdata, 32'hA5A5_A5A5);
    step(1, 0, 1, 2'd2, 32'hCAFE_F00D, 0, 0, 3'b000);
    chk("R8", {31'b0, rf_we}, 32'h0);
    step(1, 0, 1, 2'd0, 32'hCAFE_F00D, 0, 0, 3'b000);
    chk("R3", ld_data, 32'hCAFE_F00D);

    for (int i = 0; i < 3000; i++) begin
      int kind;
      kind = $urandom_range(0, 2);
      step(kind == 1, kind == 2, $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
           $urandom, $urandom, $urandom_range(0, 7) == 0, 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule